// File: doc/BRIEF.md
# Bit-Sliced Integer ALU with Overflow Flags

This block is a purely combinational integer ALU of parameterised width, 32 bits by default. It is assembled from identical one-bit cells. Each cell forms the bitwise AND, the bitwise OR and a full-adder sum of its pair of operand bits, and a per-cell multiplexer picks one of them. Carries ripple from each cell to the next, starting at bit 0.

Subtraction reuses the same adder. Every cell inverts its B bit, and the carry into bit 0 is forced to one, so the chain computes A + ~B + 1. Alongside the result, the block reports three things: the carry out of the top cell, a two's-complement overflow flag and an unsigned overflow (or borrow) flag.

The block only flags overflow. Any trap or recovery is left to the logic around it. An execution stage would drive it from its decoded opcode and read all outputs in the same cycle.

Top module: `bitslice_alu`

## Requirements
- R1: With op = 2'b00 (AND), result equals the bitwise AND of a and b.
- R2: With op = 2'b01 (OR), result equals the bitwise OR of a and b.
- R3: With op = 2'b10 (ADD), result equals (a + b) mod 2^WIDTH, and carry_out equals bit WIDTH of the true unsigned sum.
- R4: With op = 2'b11 (SUB), result equals (a - b) mod 2^WIDTH, and carry_out equals the carry out of a + ~b + 1, which is 1 exactly when a >= b unsigned.
- R5: With op = ADD, ovf_unsigned is 1 exactly when the truncated result is smaller than a as an unsigned number.
- R6: With op = SUB, ovf_unsigned is 1 exactly when a < b as unsigned numbers, meaning a borrow occurred.
- R7: With op = ADD, ovf_signed is 1 exactly when a and b share a sign bit and the sign bit of result differs from it.
- R8: With op = SUB, ovf_signed is 1 exactly when a and ~b share a sign bit and the sign bit of result differs from it. This is the same as the true difference falling outside the two's-complement range.
- R9: With op = AND or op = OR, ovf_signed and ovf_unsigned are both 0 whatever the operands are.
- R10: Negation through SUB with a = 0 behaves as follows. For b = 0 it gives result 0 with both flags 0. For b equal to the most negative value it gives that same value back, with ovf_signed = 1.
- R11: With op = AND or op = OR, carry_out reports the carry out of a + b, because the adder chain runs uninverted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a | input | WIDTH | Operand A |
| b | input | WIDTH | Operand B |
| op | input | 2 | Operation: 00 AND, 01 OR, 10 ADD, 11 SUB |
| result | output | WIDTH | Operation result |
| carry_out | output | 1 | Carry out of the top slice |
| ovf_signed | output | 1 | Two's-complement overflow |
| ovf_unsigned | output | 1 | Unsigned overflow on ADD, borrow on SUB |

## Verification
The operand corner set is {0, 1, all-ones, most-positive, most-negative}, and every pair from it is run through all four operations. These pairs separate the carry that leaves the top slice from the sign change at the boundary between positive and negative values. They also separate a genuine borrow from an equal-operand subtraction. Directed AND and OR patterns with alternating bits show that the bitwise path never mixes with the adder sum. Negation cases and seeded random operands check the B-invert and carry-in path across the whole carry chain.

// File: rtl/bitslice_alu_pkg.sv
// Package: shared operation encoding for the bit-sliced ALU.
// Assumes: two-bit opcode; the encoding is visible on the top-level op port.
package bitslice_alu_pkg;

    typedef enum logic [1:0] {
        OP_AND = 2'b00,
        OP_OR  = 2'b01,
        OP_ADD = 2'b10,
        OP_SUB = 2'b11
    } alu_op_e;

endpackage

// File: rtl/alu_bit_slice.sv
// Module: one bit of the ALU. Forms AND, OR and a full-adder sum of its
// operand bits and selects one of them. B can be inverted for subtraction.
// Assumes: the caller chains cout into the next slice's cin.
module alu_bit_slice
    import bitslice_alu_pkg::*;
(
    input  logic    a_i,
    input  logic    b_i,
    input  logic    cin_i,
    input  logic    binv_i,
    input  alu_op_e op_i,
    output logic    res_o,
    output logic    cout_o
);

    logic b_eff;
    logic sum_bit;

    // Optional B inversion used by subtraction
    assign b_eff = b_i ^ binv_i;

    // Full adder: parity for the sum, majority for the carry
    assign sum_bit = a_i ^ b_eff ^ cin_i;
    assign cout_o  = (a_i & b_eff) | (a_i & cin_i) | (b_eff & cin_i);

    // Output selection between the logical and arithmetic paths
    always_comb begin
        unique case (op_i)
            OP_AND:  res_o = a_i & b_i;
            OP_OR:   res_o = a_i | b_i;
            default: res_o = sum_bit;
        endcase
    end

endmodule

// File: rtl/alu_ovf_detect.sv
// Module: derives the signed and unsigned overflow flags from the operands
// and the finished result. It does not look at the carry chain.
// Assumes: result is already truncated to WIDTH bits.
module alu_ovf_detect
    import bitslice_alu_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] a_i,
    input  logic [WIDTH-1:0] b_i,
    input  logic [WIDTH-1:0] res_i,
    input  alu_op_e          op_i,
    output logic             ovf_s_o,
    output logic             ovf_u_o
);

    localparam int MSB = WIDTH - 1;

    logic sa, sb_eff, sr;

    // Sign bits; for SUB the second addend is ~b
    assign sa     = a_i[MSB];
    assign sb_eff = (op_i == OP_SUB) ? ~b_i[MSB] : b_i[MSB];
    assign sr     = res_i[MSB];

    // Flag computation per operation class
    always_comb begin
        ovf_s_o = 1'b0;
        ovf_u_o = 1'b0;
        case (op_i)
            OP_ADD: begin
                ovf_s_o = (sa == sb_eff) && (sr != sa);
                ovf_u_o = (res_i < a_i);
            end
            OP_SUB: begin
                ovf_s_o = (sa == sb_eff) && (sr != sa);
                ovf_u_o = (res_i > a_i);
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/bitslice_alu.sv
// Module: top of the ALU. Replicates WIDTH slices with a ripple carry
// chain and drives the invert and carry-in for SUB. Adds overflow detection.
// Assumes: purely combinational use; the caller registers the outputs.
module bitslice_alu
    import bitslice_alu_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b,
    input  logic [1:0]       op,
    output logic [WIDTH-1:0] result,
    output logic             carry_out,
    output logic             ovf_signed,
    output logic             ovf_unsigned
);

    alu_op_e          op_e;
    logic             sub_mode;
    logic [WIDTH:0]   carry;

    // Opcode decode: only SUB inverts B and injects a carry of one
    assign op_e     = alu_op_e'(op);
    assign sub_mode = (op_e == OP_SUB);
    assign carry[0] = sub_mode;

    // Ripple chain of identical slices
    for (genvar i = 0; i < WIDTH; i++) begin : g_slice
        alu_bit_slice u_slice (
            .a_i    (a[i]),
            .b_i    (b[i]),
            .cin_i  (carry[i]),
            .binv_i (sub_mode),
            .op_i   (op_e),
            .res_o  (result[i]),
            .cout_o (carry[i+1])
        );
    end

    assign carry_out = carry[WIDTH];

    alu_ovf_detect #(.WIDTH(WIDTH)) u_ovf (
        .a_i     (a),
        .b_i     (b),
        .res_i   (result),
        .op_i    (op_e),
        .ovf_s_o (ovf_signed),
        .ovf_u_o (ovf_unsigned)
    );

endmodule

// File: rtl/bitslice_alu_chk.sv
// Module: assertion checker for bitslice_alu. It is bound to the top and
// checks port relations at settled values.
// Assumes: combinational block, so it uses immediate assertions.
module bitslice_alu_chk #(
    parameter int WIDTH = 32
) (
    input logic [WIDTH-1:0] a,
    input logic [WIDTH-1:0] b,
    input logic [1:0]       op,
    input logic [WIDTH-1:0] result,
    input logic             carry_out,
    input logic             ovf_signed,
    input logic             ovf_unsigned
);

    logic [WIDTH:0]   wide_sum;
    logic [WIDTH:0]   sx_sum;
    logic [WIDTH-1:0] back_sum;
    logic             known;

    assign wide_sum = {1'b0, a} + {1'b0, b};
    assign sx_sum   = {a[WIDTH-1], a} + {b[WIDTH-1], b};
    assign back_sum = result + b;
    assign known    = !$isunknown({a, b, op});

    // Port-level relations per operation
    always_comb begin
        if (known) begin
            if (op == 2'b00)
                assert_and_R1: assert (result == (a & b)) else $error("R1 AND");
            if (op == 2'b10)
                assert_add_R3: assert ({carry_out, result} == wide_sum) else $error("R3 ADD");
            if (op == 2'b11)
                assert_sub_R4: assert (back_sum == a) else $error("R4 SUB");
            if (op == 2'b10)
                assert_uovf_add_R5: assert (ovf_unsigned == carry_out) else $error("R5");
            if (op == 2'b11)
                assert_borrow_R6: assert (ovf_unsigned == !carry_out) else $error("R6");
            if (op == 2'b10)
                assert_sovf_add_R7: assert (ovf_signed == (sx_sum[WIDTH] != sx_sum[WIDTH-1]))
                    else $error("R7");
            if (op[1] == 1'b0)
                assert_no_overflow_R9: assert (!ovf_signed && !ovf_unsigned) else $error("R9");
        end
    end

endmodule

bind bitslice_alu bitslice_alu_chk #(.WIDTH(WIDTH)) u_chk (
    .a            (a),
    .b            (b),
    .op           (op),
    .result       (result),
    .carry_out    (carry_out),
    .ovf_signed   (ovf_signed),
    .ovf_unsigned (ovf_unsigned)
);

// File: tb/bitslice_alu_tb.sv
// Bench: directed scenarios against a behavioural model of the ALU.
module bitslice_alu_tb;

    localparam int  W          = 32;
    localparam time CLK_PERIOD = 10ns;
    localparam longint WATCHDOG_CYCLES = 200000;

    logic         clk = 1'b0;
    logic [W-1:0] a, b, result;
    logic [1:0]   op;
    logic         carry_out, ovf_signed, ovf_unsigned;
    int           checks = 0;
    int           errors = 0;
    bit           done   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    bitslice_alu #(.WIDTH(W)) u_dut (
        .a(a), .b(b), .op(op), .result(result),
        .carry_out(carry_out), .ovf_signed(ovf_signed), .ovf_unsigned(ovf_unsigned)
    );

    // Apply one vector, wait, compare with the model derived from the requirements
    task automatic check_op(input string req, input logic [1:0] o,
                            input logic [W-1:0] x, input logic [W-1:0] y);
        logic [W-1:0] er;
        logic         ec, es, eu;
        longint       sx, sy, st;
        longint unsigned ux, uy;
        ux = longint'(x); uy = longint'(y);
        sx = longint'($signed(x)); sy = longint'($signed(y));
        es = 1'b0; eu = 1'b0;
        ec = ((ux + uy) >> W) != 0;
        case (o)
            2'b00: er = x & y;
            2'b01: er = x | y;
            2'b10: begin
                er = x + y;
                eu = ec;
                st = sx + sy;
                es = (st > longint'(2**(W-1) - 1)) || (st < -longint'(2**(W-1)));
            end
            default: begin
                er = x - y;
                ec = (ux >= uy);
                eu = (ux < uy);
                st = sx - sy;
                es = (st > longint'(2**(W-1) - 1)) || (st < -longint'(2**(W-1)));
            end
        endcase
        a = x; b = y; op = o;
        #(CLK_PERIOD/2);
        checks++;
        if ({result, carry_out, ovf_signed, ovf_unsigned} !== {er, ec, es, eu}) begin
            errors++;
            $display("FAIL %s op=%b a=%h b=%h: actual res=%h c=%b s=%b u=%b expected res=%h c=%b s=%b u=%b",
                     req, o, x, y, result, carry_out, ovf_signed, ovf_unsigned, er, ec, es, eu);
        end
        #(CLK_PERIOD/2);
    endtask

    task automatic test_idle();
        check_op("R3 idle zeros", 2'b10, '0, '0);
        check_op("R1 idle zeros", 2'b00, '0, '0);
    endtask

    task automatic test_logic();
        check_op("R1 AND alternating", 2'b00, 32'hAAAA_5555, 32'hFFFF_0F0F);
        check_op("R1 AND ones", 2'b00, '1, 32'h1234_5678);
        check_op("R2 OR alternating", 2'b01, 32'hAAAA_0000, 32'h5555_000F);
        check_op("R2 OR zero", 2'b01, '0, 32'h8000_0001);
        check_op("R9 R11 AND carry", 2'b00, '1, 32'h1);
        check_op("R9 R11 OR carry", 2'b01, 32'h8000_0000, 32'h8000_0000);
        check_op("R9 R11 OR signed wrap", 2'b01, 32'h7FFF_FFFF, 32'h7FFF_FFFF);
    endtask

    task automatic test_corners();
        logic [W-1:0] cv [5] = '{32'h0, 32'h1, 32'hFFFF_FFFF, 32'h7FFF_FFFF, 32'h8000_0000};
        for (int i = 0; i < 5; i++)
            for (int j = 0; j < 5; j++) begin
                check_op("R3 R5 R7 add corner", 2'b10, cv[i], cv[j]);
                check_op("R4 R6 R8 sub corner", 2'b11, cv[i], cv[j]);
                check_op("R9 R11 and corner", 2'b00, cv[i], cv[j]);
                check_op("R9 R11 or corner", 2'b01, cv[i], cv[j]);
            end
    endtask

    task automatic test_sub_signs();
        check_op("R8 pos minus neg", 2'b11, 32'h7FFF_FFFF, 32'hFFFF_FFFF);
        check_op("R8 neg minus pos", 2'b11, 32'h8000_0000, 32'h1);
        check_op("R6 equal operands", 2'b11, 32'h1234_5678, 32'h1234_5678);
        check_op("R6 borrow", 2'b11, 32'h5, 32'h6);
    endtask

    task automatic test_negate();
        check_op("R10 negate zero", 2'b11, '0, '0);
        check_op("R10 negate min", 2'b11, '0, 32'h8000_0000);
        check_op("R10 negate one", 2'b11, '0, 32'h1);
    endtask

    task automatic test_random();
        for (int k = 0; k < 400; k++)
            check_op("R3 R4 R5 R6 R7 R8 random", 2'(k % 4), $urandom(), $urandom());
    endtask

    // Watchdog: a hung run counts as a failure and still reports
    initial begin
        repeat (WATCHDOG_CYCLES) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired: actual running expected finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    // Scenario sequence
    initial begin
        a = '0; b = '0; op = 2'b00;
        void'($urandom(32'd375));
        #(CLK_PERIOD);
        test_idle();
        test_logic();
        test_corners();
        test_sub_signs();
        test_negate();
        test_random();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule